// File: doc/BRIEF.md
# SPI Target with Stall Timeout

This block is the target (slave) end of an SPI link. Three external lines, SCK, the active-low select and MOSI, are brought into the system clock domain through two-flop synchronisers, and the edges of the synchronised clock are found there. The block drives MISO from the same domain. While the select is low, the block shifts one byte in on each eight sampling edges. A byte that is not fully received is dropped when the select goes high.

A single 18-bit control word sets the framing: bit order, clock polarity and clock phase. The same word holds the receive enable, the receive interrupt enable, the two DMA request enables, a run enable and a stall timeout. The bit order, polarity and phase can only be changed while the run enable is low. The receive side holds one byte, with a valid flag and an overrun flag. The transmit side holds one byte; when it is empty, 0xFF is sent.

The stall timeout learns the bit time from the system-clock gap between the first two sampling edges of a transfer. It then flags a transfer whose select stays low with no sampling edge for the programmed number of bit times. Status flags are cleared by a five-bit clear strobe. The external SCK must run at no more than a quarter of the system clock.

Top module: `spi_tgt_top`

## Requirements
- R1: After reset the control word reads 0x00088 (receive enable bit 3 and run enable bit 7 set, all else 0). The receive valid, overrun, interrupt and timeout outputs are 0, and MISO is 1.
- R2: Control bit 0 = 0 shifts the most significant bit first and bit 0 = 1 shifts the least significant bit first. The setting applies to both MOSI and MISO.
- R3: Control bit 1 is the SCK idle level, and control bit 2 = 0 samples on the first edge of each bit while bit 2 = 1 samples on the second. A byte is exchanged correctly in all four combinations.
- R4: While the current run enable (bit 7) is 1, a control write leaves bits [2:0] unchanged. While run is 0, SCK is ignored, no byte is received and MISO stays 1.
- R5: A completed byte is stored and shown on rx_valid_o only when bit 3 is set. An accepted byte sets rx_irq_o when bit 4 is set, and a rx_rd pulse clears rx_valid_o.
- R6: A byte that completes while rx_valid_o is 1 and no read is pending sets rx_ovr_o. The new byte is discarded, and rx_data_o keeps the older byte.
- R7: A byte written to the transmit register is sent in the next byte slot of the transfer. A slot with no byte waiting sends 0xFF.
- R8: A rising select discards any partial byte, so the next transfer starts at bit 0.
- R9: The bit time is the number of system clocks between the first two sampling edges of a transfer. The timeout flag is set when the select stays low with no sampling edge for (bits [15:8]) × bit-time clocks and bit 16 is 1. A window of 0 never fires, and to_irq_o also needs bit 17.
- R10: The clear strobe works bit by bit: bit 0 clears the overrun flag, bit 1 empties the transmit register, bit 2 empties the receive register, bit 3 clears the receive interrupt and bit 4 clears the timeout flag.
- R11: With bit 5 set, tx_dma_req_o is high while running with an empty transmit register. With bit 6 set, rx_dma_req_o is high while a received byte waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the controller |
| cs_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 18 | Control word write value |
| cfg_o | output | 18 | Current control word |
| clr_we | input | 1 | Clear strobe |
| clr_bits | input | 5 | Per-flag clear mask |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_wdata | input | 8 | Transmit byte |
| rx_rd | input | 1 | Receive byte consumed |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte waiting |
| rx_ovr_o | output | 1 | Receive overrun flag |
| rx_irq_o | output | 1 | Receive interrupt |
| timeout_o | output | 1 | Stall timeout flag |
| to_irq_o | output | 1 | Timeout interrupt |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |

## Verification
The bench runs a transfer in each of the four clock modes, with both bit orders, and compares the bytes seen on both data lines. A wrong edge choice or a reversed shift shows up there as a bit-shifted or mirrored byte. Two further tests cover a byte cut short by the select, which would otherwise leave the next byte misaligned, and a second byte arriving before the first is read, which must raise the overrun flag and not overwrite the first byte. The timeout is checked by watching the flag in a band of cycles around window × bit time after the last sampling edge; a timer counting the wrong unit or a gap off by a bit period fires outside that band. It is also checked that a window of zero never fires, that the interrupt is gated on its enable, and that framing writes made while running are ignored.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  localparam int BYTE_W = 8;
  localparam int BC_W   = $clog2(BYTE_W);
  localparam int CFG_W  = 18;

  // control word, bit 17 first down to bit 0
  typedef struct packed {
    logic       toint_en;  // 17
    logic       to_en;     // 16
    logic [7:0] to_win;    // 15:8
    logic       run;       // 7
    logic       dma_rx;    // 6
    logic       dma_tx;    // 5
    logic       rxint_en;  // 4
    logic       rx_en;     // 3
    logic       cpha;      // 2
    logic       cpol;      // 1
    logic       lsb_first; // 0
  } cfg_t;

  localparam logic [CFG_W-1:0] CFG_RST = 18'h00088;

  // position within a byte of the bit exchanged in slot n
  function automatic logic [BC_W-1:0] slot_pos(input logic [BC_W-1:0] n, input logic lsb);
    return lsb ? n : BC_W'(BYTE_W - 1) - n;
  endfunction

  // shift register update with one received bit
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] sh,
                                                 input logic b, input logic lsb);
    return lsb ? {b, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], b};
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int               W       = 1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
  import spi_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              lsb_first,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              run,
  input  logic [BYTE_W-1:0] tx_next,
  output logic              active,
  output logic              samp_evt,
  output logic              byte_evt,
  output logic              load_req,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  logic              sck_d_q, cs_n_d_q;
  logic [BC_W-1:0]   bit_cnt_q;
  logic [BYTE_W-1:0] rx_sh_q, tx_cur_q;
  logic              rise, fall, lead, trail, cs_start;

  always_comb begin
    active   = run && !cs_n_s;
    rise     = sck_s && !sck_d_q;
    fall     = !sck_s && sck_d_q;
    lead     = cpol ? fall : rise;
    trail    = cpol ? rise : fall;
    samp_evt = active && (cpha ? trail : lead);
    byte_evt = samp_evt && (bit_cnt_q == BC_W'(BYTE_W - 1));
    cs_start = run && !cs_n_s && cs_n_d_q;
    load_req = cs_start || byte_evt;
    rx_byte  = shift_in(rx_sh_q, mosi_s, lsb_first);
    miso     = active ? tx_cur_q[slot_pos(bit_cnt_q, lsb_first)] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q   <= 1'b0;
      cs_n_d_q  <= 1'b1;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      tx_cur_q  <= '1;
    end else begin
      sck_d_q  <= sck_s;
      cs_n_d_q <= cs_n_s;
      if (!active) begin
        bit_cnt_q <= '0;
        rx_sh_q   <= '0;
      end else if (samp_evt) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        rx_sh_q   <= rx_byte;
      end
      if (load_req) tx_cur_q <= tx_next;
    end
  end

  AST_FRESH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_s) |-> bit_cnt_q == '0); // R8

endmodule

// File: rtl/spi_tgt_timer.sv
module spi_tgt_timer #(
  parameter int BT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       samp_evt,
  input  logic       to_en,
  input  logic [7:0] win,
  output logic       to_hit
);
  localparam int CW = BT_W + 8;

  typedef enum logic [1:0] {EDGE_NONE, EDGE_ONE, EDGE_KNOWN} phase_e;

  phase_e          phase_q;
  logic [CW-1:0]   idle_q, gap, limit;
  logic [BT_W-1:0] bt_q, bt_next;

  function automatic logic [CW-1:0] stall_limit(input logic [7:0] w, input logic [BT_W-1:0] bt);
    return CW'(w) * CW'(bt);
  endfunction

  always_comb begin
    gap     = idle_q + 1'b1;
    bt_next = (|gap[CW-1:BT_W]) ? '1 : gap[BT_W-1:0];
    limit   = stall_limit(win, bt_q);
    to_hit  = active && to_en && (phase_q == EDGE_KNOWN) && (win != '0)
              && !samp_evt && (gap == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= EDGE_NONE;
      idle_q  <= '0;
      bt_q    <= '0;
    end else if (!active) begin
      phase_q <= EDGE_NONE;
      idle_q  <= '0;
      bt_q    <= '0;
    end else if (samp_evt) begin
      idle_q <= '0;
      if (phase_q == EDGE_ONE) bt_q <= bt_next;
      phase_q <= (phase_q == EDGE_NONE) ? EDGE_ONE : EDGE_KNOWN;
    end else if (idle_q != '1) begin
      idle_q <= gap;
    end
  end

  AST_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    samp_evt |=> idle_q == '0); // R9

  AST_BT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |-> bt_q != '0); // R9

endmodule

// File: rtl/spi_tgt_top.sv
module spi_tgt_top
  import spi_tgt_pkg::*;
#(
  parameter int BT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_o,
  input  logic              clr_we,
  input  logic [4:0]        clr_bits,
  input  logic              tx_we,
  input  logic [BYTE_W-1:0] tx_wdata,
  input  logic              rx_rd,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_ovr_o,
  output logic              rx_irq_o,
  output logic              timeout_o,
  output logic              to_irq_o,
  output logic              tx_dma_req_o,
  output logic              rx_dma_req_o
);
  cfg_t              cfg_q;
  logic [2:0]        sync_q;
  logic              sck_s, cs_n_s, mosi_s;
  logic              active, samp_evt, byte_evt, load_req, to_hit;
  logic [BYTE_W-1:0] rx_byte, tx_next, tx_q, rx_q;
  logic              tx_full_q, rx_valid_q, ovr_q, rx_irq_q, to_flag_q;
  logic              byte_ok, byte_lost;
  logic              clr_ovr, clr_tx, clr_rx, clr_rxirq, clr_to;

  spi_tgt_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({mosi_i, cs_n_i, sck_i}), .q_o(sync_q));
  assign {mosi_s, cs_n_s, sck_s} = sync_q;

  spi_tgt_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .lsb_first(cfg_q.lsb_first), .cpol(cfg_q.cpol), .cpha(cfg_q.cpha), .run(cfg_q.run),
    .tx_next(tx_next), .active(active), .samp_evt(samp_evt), .byte_evt(byte_evt),
    .load_req(load_req), .rx_byte(rx_byte), .miso(miso_o));

  spi_tgt_timer #(.BT_W(BT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(active), .samp_evt(samp_evt),
    .to_en(cfg_q.to_en), .win(cfg_q.to_win), .to_hit(to_hit));

  always_comb begin
    {clr_to, clr_rxirq, clr_rx, clr_tx, clr_ovr} = clr_we ? clr_bits : 5'b0;
    tx_next   = tx_full_q ? tx_q : '1;
    byte_lost = byte_evt && cfg_q.rx_en && rx_valid_q && !rx_rd;
    byte_ok   = byte_evt && cfg_q.rx_en && !byte_lost;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= cfg_t'(CFG_RST);
      tx_q       <= '0;
      tx_full_q  <= 1'b0;
      rx_q       <= '0;
      rx_valid_q <= 1'b0;
      ovr_q      <= 1'b0;
      rx_irq_q   <= 1'b0;
      to_flag_q  <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q <= cfg_t'(cfg_wdata);
        if (cfg_q.run) cfg_q[2:0] <= cfg_q[2:0];
      end
      // transmit holding byte
      if (load_req || clr_tx) tx_full_q <= 1'b0;
      if (tx_we) begin
        tx_q      <= tx_wdata;
        tx_full_q <= 1'b1;
      end
      // receive holding byte
      if (rx_rd || clr_rx) rx_valid_q <= 1'b0;
      if (byte_ok) begin
        rx_q       <= rx_byte;
        rx_valid_q <= 1'b1;
      end
      if (clr_ovr) ovr_q <= 1'b0;
      if (byte_lost) ovr_q <= 1'b1;
      if (clr_rxirq) rx_irq_q <= 1'b0;
      if (byte_ok && cfg_q.rxint_en) rx_irq_q <= 1'b1;
      if (clr_to) to_flag_q <= 1'b0;
      if (to_hit) to_flag_q <= 1'b1;
    end
  end

  assign cfg_o        = cfg_q;
  assign rx_data_o    = rx_q;
  assign rx_valid_o   = rx_valid_q;
  assign rx_ovr_o     = ovr_q;
  assign rx_irq_o     = rx_irq_q;
  assign timeout_o    = to_flag_q;
  assign to_irq_o     = to_flag_q && cfg_q.toint_en;
  assign tx_dma_req_o = cfg_q.dma_tx && cfg_q.run && !tx_full_q;
  assign rx_dma_req_o = cfg_q.dma_rx && rx_valid_q;

  AST_FRAME_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.run |=> $stable(cfg_q[2:0])); // R4

  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_lost |=> (ovr_q && $stable(rx_q))); // R6

  AST_RXIRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq_q) |-> $past(byte_ok && cfg_q.rxint_en)); // R5

  AST_TO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag_q) |-> $past(cfg_q.to_en && active)); // R9

endmodule

// File: tb/spi_tgt_top_tb_top.sv
module spi_tgt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic        cfg_we = 1'b0, clr_we = 1'b0, tx_we = 1'b0, rx_rd = 1'b0;
  logic [17:0] cfg_wdata = '0, cfg_o;
  logic [4:0]  clr_bits = '0;
  logic [7:0]  tx_wdata = '0, rx_data;
  logic        rx_valid, rx_ovr, rx_irq, to_flag, to_irq, txdma, rxdma;

  int checks = 0, errors = 0, cyc = 0, last_samp = 0;
  bit done = 0;
  bit m_cpol = 0, m_cpha = 0, m_lsb = 0;
  logic [7:0] got;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  spi_tgt_top dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi), .miso_o(miso),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_o(cfg_o), .clr_we(clr_we),
    .clr_bits(clr_bits), .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ovr_o(rx_ovr), .rx_irq_o(rx_irq),
    .timeout_o(to_flag), .to_irq_o(to_irq), .tx_dma_req_o(txdma), .rx_dma_req_o(rxdma));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [17:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  // framing takes effect only with run low, so drop run first
  task automatic set_cfg(input logic [17:0] v);
    m_lsb = v[0]; m_cpol = v[1]; m_cpha = v[2];
    sck = m_cpol;
    wr_cfg(v & ~18'h80);
    wr_cfg(v);
  endtask

  task automatic clr(input logic [4:0] m);
    @(negedge clk); clr_we = 1; clr_bits = m;
    @(negedge clk); clr_we = 0;
  endtask

  task automatic tx_put(input logic [7:0] b);
    @(negedge clk); tx_we = 1; tx_wdata = b;
    @(negedge clk); tx_we = 0;
  endtask

  task automatic rd_rx();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic cs_on();  cs_n = 0; tick(8); endtask
  task automatic cs_off(); tick(4); cs_n = 1; tick(8); endtask

  // controller side of one byte, nbits < 8 gives a cut-short byte
  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi, input int nbits = 8);
    mi = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      int k;
      k = m_lsb ? i : 7 - i;
      if (!m_cpha) begin
        mosi = mo[k]; tick(4);
        sck = ~m_cpol; mi[k] = miso; last_samp = cyc;
        tick(4); sck = m_cpol;
      end else begin
        tick(4); sck = ~m_cpol; mosi = mo[k];
        tick(4); sck = m_cpol; mi[k] = miso; last_samp = cyc;
      end
    end
    tick(6);
  endtask

  task automatic wait_rel(input int n);
    while (cyc < last_samp + n) tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1; tick(2);
    // R1 reset state
    check("R1 cfg", cfg_o, 18'h00088);
    check("R1 flags", {rx_valid, rx_ovr, rx_irq, to_flag, to_irq}, 5'b0);
    check("R1 miso idle", miso, 1'b1);

    // R7 R2 basic exchange, msb first
    tx_put(8'hA5); cs_on(); xfer(8'h3C, got); cs_off();
    check("R7 miso byte", got, 8'hA5);
    check("R2 msb rx", rx_data, 8'h3C);
    check("R5 valid", rx_valid, 1'b1);
    check("R5 no irq when disabled", rx_irq, 1'b0);
    rd_rx(); check("R5 read clears", rx_valid, 1'b0);

    // R3 R2 all clock modes, both orders
    for (int m = 0; m < 4; m++) begin
      logic [7:0] tb, rb;
      tb = 8'h5A + 8'(m * 23); rb = 8'hC3 - 8'(m * 41);
      set_cfg(18'h88 | 18'(m << 1) | 18'((m == 1 || m == 2) ? 1 : 0));
      tx_put(tb); cs_on(); xfer(rb, got); cs_off();
      check("R3 mode miso", got, tb);
      check("R3 mode mosi", rx_data, rb);
      rd_rx();
    end
    set_cfg(18'h88);

    // R7 empty transmit slot sends 0xFF
    tx_put(8'h12); cs_on(); xfer(8'h01, got);
    check("R7 first slot", got, 8'h12);
    rd_rx(); xfer(8'h02, got); cs_off();
    check("R7 empty slot", got, 8'hFF);
    rd_rx();

    // R6 overrun keeps the first byte; R10 bit0 clears
    cs_on(); xfer(8'h11, got); xfer(8'h22, got); cs_off();
    check("R6 overrun set", rx_ovr, 1'b1);
    check("R6 older byte kept", rx_data, 8'h11);
    clr(5'b00001); check("R10 ovr clear", rx_ovr, 1'b0);
    rd_rx();

    // R5 interrupt, R10 bit3
    set_cfg(18'h98);
    cs_on(); xfer(8'h77, got); cs_off();
    check("R5 irq set", rx_irq, 1'b1);
    clr(5'b01000); check("R10 rxirq clear", rx_irq, 1'b0);
    rd_rx();
    set_cfg(18'h80);  // receive off
    cs_on(); xfer(8'h66, got); cs_off();
    check("R5 rx disabled", rx_valid, 1'b0);
    set_cfg(18'h88);

    // R4 framing write ignored while running
    wr_cfg(18'h8F);
    check("R4 frame locked", cfg_o, 18'h00088);
    cs_on(); xfer(8'h81, got); cs_off();
    check("R4 still msb first", rx_data, 8'h81);
    rd_rx();
    wr_cfg(18'h08);
    tx_put(8'h00); cs_on(); xfer(8'h42, got); cs_off();
    check("R4 stopped no rx", rx_valid, 1'b0);
    check("R4 stopped miso", got, 8'hFF);
    clr(5'b00010);
    wr_cfg(18'h88);

    // R8 cut-short byte dropped
    cs_on(); xfer(8'hF0, got, 3); cs_off();
    check("R8 no partial", rx_valid, 1'b0);
    cs_on(); xfer(8'h9D, got); cs_off();
    check("R8 realigned", rx_data, 8'h9D);
    rd_rx();

    // R9 timeout: window 3, bit time 8 clocks
    set_cfg(18'h30388);
    cs_on(); xfer(8'h01, got);
    wait_rel(18); check("R9 not yet", to_flag, 1'b0);
    wait_rel(36); check("R9 fired", to_flag, 1'b1);
    check("R9 irq", to_irq, 1'b1);
    cs_off(); rd_rx();
    clr(5'b10000); check("R10 to clear", to_flag, 1'b0);
    set_cfg(18'h10388);
    cs_on(); xfer(8'h02, got); wait_rel(40);
    check("R9 flag without irq en", to_flag, 1'b1);
    check("R9 irq gated", to_irq, 1'b0);
    cs_off(); rd_rx(); clr(5'b10000);
    set_cfg(18'h30088);
    cs_on(); xfer(8'h03, got); xfer(8'h04, got); wait_rel(200);
    check("R9 window zero", to_flag, 1'b0);
    cs_off(); rd_rx();

    // R10 flushes
    set_cfg(18'h88);
    tx_put(8'h3E); clr(5'b00010);
    cs_on(); xfer(8'h55, got); cs_off();
    check("R10 tx flush", got, 8'hFF);
    clr(5'b00100); check("R10 rx flush", rx_valid, 1'b0);

    // R11 DMA requests
    set_cfg(18'hE8);
    check("R11 tx req empty", txdma, 1'b1);
    tx_put(8'h01); check("R11 tx req full", txdma, 1'b0);
    check("R11 rx req idle", rxdma, 1'b0);
    cs_on(); xfer(8'hAB, got); cs_off();
    check("R11 rx req", rxdma, 1'b1);
    rd_rx(); check("R11 rx req drop", rxdma, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule